// File: doc/BRIEF.md
# Serial Systematic CRC Encoder

This block forms a systematic cyclic-code codeword one bit per clock. A message of any length enters serially, most significant bit first. Each accepted message bit is copied to the serial output unchanged and also fed into a modulo-2 divider. The divider is a chain of one-bit stages with XOR taps chosen by a polynomial parameter. Once the last message bit has been taken, the divider's feedback is switched off. The stages are then shifted out behind the message, so the codeword carries the remainder as its check field.

A frame opens with a start marker that comes with its first valid bit. The start marker clears the divider so that the first bit meets an all-zero remainder. The last message bit carries an end marker. The check-field phase that follows is self-timed and lasts exactly as many cycles as the polynomial degree. A one-cycle completion flag rides on the final check bit. The next frame may begin in the very cycle that flag is visible.

Top module: `crc_ser_enc`

## Requirements
- R1: The divider holds DEG one-bit stages. Bit i of parameter POLY (i < DEG) is the coefficient of X^i in the divisor, and the X^DEG term is implied. A tap XOR sits at stage i only where POLY[i] is 1.
- R2: When in_valid_i and sof_i are both high outside the check-field phase, all stages are cleared and that bit is the first message bit. This holds even if an earlier frame was still taking message bits.
- R3: Every accepted message bit appears on out_bit_o, with out_valid_o high, in the cycle after it is accepted.
- R4: After the bit marked by eom_i, the DEG stage values leave on out_bit_o on DEG consecutive cycles, top stage (X^(DEG-1) coefficient) first, with no feedback applied.
- R5: The output stream of a frame equals the message times X^DEG plus the modulo-2 remainder of that product by the divisor. For message 1010001101 with POLY 5'b10101 (DEG 5), the check field is 01110.
- R6: Per frame, out_valid_o is high for exactly k+DEG cycles for a k-bit message, including k = 1 and messages whose valid bits are separated by idle cycles.
- R7: done_o is high for exactly one cycle per frame, in the cycle that carries the last check bit.
- R8: in_valid_i is ignored during the check-field phase. A valid bit without sof_i while no frame is open is also ignored. Neither produces output or changes the check field.
- R9: A frame whose first bit is presented while done_o is high is accepted, and both codewords come out back to back with no idle cycle.
- R10: While rst_n is low, and after it is released, out_valid_o and done_o are low until a frame is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Message bit qualifier |
| in_bit_i | input | 1 | Serial message bit |
| sof_i | input | 1 | First bit of a frame |
| eom_i | input | 1 | Last bit of the message |
| out_bit_o | output | 1 | Serial codeword bit |
| out_valid_o | output | 1 | Codeword bit qualifier |
| done_o | output | 1 | Last check bit of the frame |

## Verification
The bench builds two instances that share one stimulus. The first has a degree-5 divisor, POLY 5'b10101, which brings the hand-worked frame and a short check field within reach. The second has a degree-16 divisor, POLY 16'h1021, whose check field outlasts short messages. That exposes tap placement across a wide register and shows that input valid is ignored during a long shift-out. Codewords from both instances are compared with a long-division model. The back-to-back start and the mid-frame restart are run against the degree-5 instance.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MSG  = 2'd1,
        PH_FCS  = 2'd2
    } phase_e;

endpackage

// File: rtl/crc_ser_divider.sv
module crc_ser_divider #(
    parameter int unsigned        DEG  = 5,
    parameter logic [DEG-1:0]     POLY = 5'b10101
) (
    input  logic [DEG-1:0] rem_i,
    input  logic           bit_i,
    input  logic           fb_en_i,
    output logic [DEG-1:0] rem_o
);

    logic fb;

    // feedback = top stage XOR incoming bit, gated off during shift-out
    assign fb = fb_en_i & (rem_i[DEG-1] ^ bit_i);

    for (genvar i = 0; i < DEG; i++) begin : g_stage
        if (i == 0) begin : g_low
            if (POLY[0]) begin : g_tap
                assign rem_o[0] = fb;
            end else begin : g_notap
                assign rem_o[0] = 1'b0;
            end
        end else begin : g_up
            if (POLY[i]) begin : g_tap
                assign rem_o[i] = rem_i[i-1] ^ fb;
            end else begin : g_notap
                assign rem_o[i] = rem_i[i-1];
            end
        end
    end

endmodule

// File: rtl/crc_ser_phase_ctl.sv
module crc_ser_phase_ctl
    import crc_ser_pkg::*;
#(
    parameter int unsigned DEG   = 5,
    parameter int unsigned CNT_W = 3
) (
    input  phase_e             phase_q,
    input  logic [CNT_W-1:0]   cnt_q,
    input  logic               in_valid_i,
    input  logic               sof_i,
    input  logic               eom_i,
    output phase_e             phase_d,
    output logic [CNT_W-1:0]   cnt_d,
    output logic               take_o,
    output logic               clear_o,
    output logic               shift_o,
    output logic               last_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEG - 1);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        clear_o = 1'b0;
        take_o  = 1'b0;
        shift_o = 1'b0;
        last_o  = 1'b0;

        if (phase_q == PH_FCS) begin
            shift_o = 1'b1;
            if (cnt_q == LAST_CNT) begin
                last_o  = 1'b1;
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (in_valid_i) begin
            if (sof_i) begin
                clear_o = 1'b1;
                take_o  = 1'b1;
            end else if (phase_q == PH_MSG) begin
                take_o = 1'b1;
            end
            if (take_o) begin
                cnt_d   = '0;
                phase_d = eom_i ? PH_FCS : PH_MSG;
            end
        end
    end

endmodule

// File: rtl/crc_ser_enc.sv
module crc_ser_enc
    import crc_ser_pkg::*;
#(
    parameter int unsigned    DEG  = 5,
    parameter logic [DEG-1:0] POLY = 5'b10101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid_i,
    input  logic in_bit_i,
    input  logic sof_i,
    input  logic eom_i,
    output logic out_bit_o,
    output logic out_valid_o,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(DEG + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [DEG-1:0]   rem;
        logic             obit;
        logic             ovld;
        logic             done;
    } state_t;

    state_t state_d, state_q;

    phase_e           phase_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             take, clear, shift, last;
    logic [DEG-1:0]   rem_base, rem_step;
    phase_e           phase_w;

    assign phase_w = state_q.phase;

    crc_ser_phase_ctl #(
        .DEG   (DEG),
        .CNT_W (CNT_W)
    ) u_ctl (
        .phase_q    (state_q.phase),
        .cnt_q      (state_q.cnt),
        .in_valid_i (in_valid_i),
        .sof_i      (sof_i),
        .eom_i      (eom_i),
        .phase_d    (phase_nx),
        .cnt_d      (cnt_nx),
        .take_o     (take),
        .clear_o    (clear),
        .shift_o    (shift),
        .last_o     (last)
    );

    assign rem_base = clear ? '0 : state_q.rem;

    crc_ser_divider #(
        .DEG  (DEG),
        .POLY (POLY)
    ) u_div (
        .rem_i   (rem_base),
        .bit_i   (in_bit_i),
        .fb_en_i (take),
        .rem_o   (rem_step)
    );

    always_comb begin
        state_d       = state_q;
        state_d.phase = phase_nx;
        state_d.cnt   = cnt_nx;
        state_d.ovld  = take | shift;
        state_d.done  = last;
        state_d.obit  = take ? in_bit_i : state_q.rem[DEG-1];
        if (take || shift) begin
            state_d.rem = rem_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, cnt: '0, rem: '0,
                         obit: 1'b0, ovld: 1'b0, done: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign out_bit_o   = state_q.obit;
    assign out_valid_o = state_q.ovld;
    assign done_o      = state_q.done;

endmodule

// File: rtl/crc_ser_enc_chk.sv
module crc_ser_enc_chk
    import crc_ser_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   in_valid_i,
    input logic   in_bit_i,
    input logic   sof_i,
    input logic   out_bit_o,
    input logic   out_valid_o,
    input logic   done_o,
    input phase_e phase
);

    // R3: accepted message bit is echoed one cycle later
    a_r3_msg_through: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && phase != PH_FCS && (sof_i || phase == PH_MSG))
        |=> (out_valid_o && out_bit_o == $past(in_bit_i)));

    // R4: check-field phase emits a bit every cycle
    a_r4_fcs_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FCS) |=> out_valid_o);

    // R7: completion flag rides on a valid bit
    a_r7_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> out_valid_o);

    // R7: completion flag lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: no output while idle unless a frame opens
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !(in_valid_i && sof_i)) |=> !out_valid_o);

    // R9: encoder is ready for a new frame when done is shown
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (phase == PH_IDLE));

endmodule

bind crc_ser_enc crc_ser_enc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_bit_i    (in_bit_i),
    .sof_i       (sof_i),
    .out_bit_o   (out_bit_o),
    .out_valid_o (out_valid_o),
    .done_o      (done_o),
    .phase       (phase_w)
);

// File: tb/crc_ser_enc_tb_top.sv
`timescale 1ns/1ps
module crc_ser_enc_tb_top;

    localparam int NVEC = 7;
    // {len, data, gap position (-1 none), junk valid after eom}
    localparam int          V_LEN [NVEC] = '{10, 1, 1, 16, 32, 7, 24};
    localparam logic [31:0] V_DAT [NVEC] = '{32'h28D, 32'h1, 32'h0, 32'hFFFF,
                                             32'hDEADBEEF, 32'h5A, 32'h1};
    localparam int          V_GAP [NVEC] = '{-1, -1, -1, 5, 20, 2, -1};
    localparam bit          V_JNK [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, sof = 1'b0, eom = 1'b0;
    logic ob5, ov5, dn5, ob16, ov16, dn16;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    crc_ser_enc #(.DEG(5), .POLY(5'b10101)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_bit_i(in_bit),
        .sof_i(sof), .eom_i(eom), .out_bit_o(ob5), .out_valid_o(ov5), .done_o(dn5));

    crc_ser_enc #(.DEG(16), .POLY(16'h1021)) dut16_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_bit_i(in_bit),
        .sof_i(sof), .eom_i(eom), .out_bit_o(ob16), .out_valid_o(ov16), .done_o(dn16));

    // output monitors, sampled 1 ns after the rising edge
    logic [79:0] cap5 = '0, cap16 = '0;
    int vc5 = 0, vc16 = 0, dc5 = 0, dc16 = 0;
    always @(posedge clk) begin
        #1;
        if (ov5)  begin cap5  = {cap5[78:0], ob5};   vc5++;  end
        if (ov16) begin cap16 = {cap16[78:0], ob16}; vc16++; end
        if (dn5)  dc5++;
        if (dn16) dc16++;
    end

    function automatic logic [15:0] ref_rem(input logic [31:0] d, input int len,
                                            input int deg, input logic [16:0] gen);
        logic [63:0] w;
        w = 64'(d) << deg;
        for (int i = len + deg - 1; i >= deg; i--)
            if (w[i]) w = w ^ (64'(gen) << (i - deg));
        return 16'(w & ((64'd1 << deg) - 1));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] d, input int len, input int gap,
                        input bit junk, input bit now, input bit do_eom);
        for (int i = len - 1; i >= 0; i--) begin
            if (i == gap) begin
                @(negedge clk); in_valid = 1'b0; sof = 1'b0; eom = 1'b0;
            end
            if (!(now && i == len - 1)) @(negedge clk);
            in_valid = 1'b1; in_bit = d[i];
            sof = (i == len - 1); eom = do_eom && (i == 0);
        end
        @(negedge clk);
        sof = 1'b0; eom = 1'b0; in_valid = junk; in_bit = 1'b1;
    endtask

    task automatic check_one(input string req, input logic [31:0] d, input int len,
                             input int deg, input logic [16:0] gen,
                             input logic [79:0] cap, input int dv, input int dd);
        int n;
        logic [63:0] exp;
        n = len + deg;
        exp = (64'(d) << deg) | 64'(ref_rem(d, len, deg, gen));
        chk(dv == n, {req, " R6 valid count"}, 64'(dv), 64'(n));
        chk(dd == 1, {req, " R7 done count"}, 64'(dd), 64'd1);
        chk((64'(cap) & ((64'd1 << n) - 1)) == exp, {req, " R5 codeword"},
            64'(cap) & ((64'd1 << n) - 1), exp);
    endtask

    task automatic run_frame(input logic [31:0] d, input int len, input int gap,
                             input bit junk, input string req);
        int v5, v16, d5, d16;
        @(negedge clk);
        v5 = vc5; v16 = vc16; d5 = dc5; d16 = dc16;
        send(d, len, gap, junk, 1'b0, 1'b1);
        repeat (22) @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_one({req, " deg5"},  d, len, 5,  17'h00035, cap5,  vc5 - v5,  dc5 - d5);
        check_one({req, " deg16"}, d, len, 16, 17'h11021, cap16, vc16 - v16, dc16 - d16);
    endtask

    task automatic run_all();
        int v5, v16, d5;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!ov5 && !dn5 && !ov16 && !dn16, "R10 outputs in reset", {ov5, dn5}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ov5 && !dn5 && vc5 == 0, "R10 outputs after reset", 64'(vc5), 0);

        // R5: hand-worked frame
        run_frame(32'h28D, 10, -1, 1'b0, "R5 worked");
        chk(cap5[4:0] == 5'b01110, "R5 worked check field", cap5[4:0], 5'b01110);
        chk(cap5[14:0] == 15'b101000110101110, "R5 worked frame", cap5[14:0],
            15'b101000110101110);

        // table walk: R1 taps, R3 pass-through, R4 order, R6 gaps, R8 junk
        for (int v = 0; v < NVEC; v++)
            run_frame(V_DAT[v], V_LEN[v], V_GAP[v], V_JNK[v], "R1 R3 R4 table");

        // R8: valid without start while idle is ignored
        @(negedge clk);
        v5 = vc5; v16 = vc16;
        in_valid = 1'b1; in_bit = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(vc5 == v5 && vc16 == v16, "R8 idle valid ignored", 64'(vc5 - v5), 0);

        // R2: restart in mid-message clears the register
        @(negedge clk);
        v5 = vc5; d5 = dc5;
        send(32'h1F, 5, -1, 1'b0, 1'b0, 1'b0);
        send(32'h28D, 10, -1, 1'b0, 1'b1, 1'b1);
        repeat (24) @(negedge clk);
        chk(vc5 - v5 == 20, "R2 restart valid count", 64'(vc5 - v5), 20);
        chk(cap5[14:0] == 15'b101000110101110, "R2 restart codeword", cap5[14:0],
            15'b101000110101110);
        chk(dc5 - d5 == 1, "R2 restart done count", 64'(dc5 - d5), 1);

        // R9: next frame presented while done is high
        @(negedge clk);
        v5 = vc5; d5 = dc5;
        send(32'h28D, 10, -1, 1'b0, 1'b0, 1'b1);
        while (!dn5) @(negedge clk);
        send(32'h155, 10, -1, 1'b0, 1'b1, 1'b1);
        repeat (24) @(negedge clk);
        chk(vc5 - v5 == 30, "R9 back-to-back valid count", 64'(vc5 - v5), 30);
        chk(dc5 - d5 == 2, "R9 back-to-back done count", 64'(dc5 - d5), 2);
        chk(cap5[29:0] == {15'b101000110101110, 10'h155, 5'(ref_rem(32'h155, 10, 5, 17'h35))},
            "R9 back-to-back stream", cap5[29:0],
            {15'b101000110101110, 10'h155, 5'(ref_rem(32'h155, 10, 5, 17'h35))});
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule